// File: doc/BRIEF.md
# Passive Color LCD Line and Frame Timing Generator

This block produces the sync and shift-clock waveforms for a single color passive LCD panel whose 8-bit pixel path is split across two 4-bit nibble buses. A programmable divider derives the pixel slot time Ts from the memory clock. A horizontal sequencer then splits every line into a non-display stretch followed by a display stretch. The line pulse sits at fixed Ts offsets inside the non-display stretch. A line counter raises the frame marker once per frame.

During the display stretch the block requests one byte per Ts slot from an upstream source. Each byte is presented on the two nibble buses for one slot. Two shift clocks run at a period of 2 Ts. Bytes in even slots are captured by the rising edge of the second shift clock, and bytes in odd slots by the falling edge of the first. The configuration inputs are held stable while the generator runs. A change of configuration is applied through a reset.

Top module: `lcd_panel_timer`

## Requirements
- R1: Ts equals `div_sel`+1 memory-clock cycles. Every output pin changes only on a Ts boundary counted from reset release.
- R2: A line lasts L = N + D Ts, with N = (`hndisp`+1)*8 non-display slots first, then D = (`hdisp`+1)*8 display slots. The values of `hndisp` are restricted to 3 or more.
- R3: `lcd_line` stays high for exactly 9 Ts in every line.
- R4: `lcd_line` rises N-27 Ts after the last shift-clock falling edge of the previous line, and falls N-18 Ts after that edge. `lcd_line` is never high while a shift clock is high.
- R5: Slots of the display stretch are numbered from 0. Both shift clocks are high in odd slots and low in even slots, which gives a period of 2 Ts and a high phase of 1 Ts. Both shift clocks stay low through the non-display stretch.
- R6: Each display slot carries one byte, with bits 7:4 on `lcd_ud` and bits 3:0 on `lcd_ld`. Even-slot bytes are captured at the `lcd_shift2` rising edge and odd-slot bytes at the `lcd_shift` falling edge. Bytes appear in the order they were requested, D per line.
- R7: A frame holds `nlines`+1 lines. `lcd_frame` is high for exactly one line period. It rises L-9 Ts before the `lcd_line` falling edge of the first line of the frame, and it falls 9 Ts after that edge.
- R8: The synchronous active-high `rst` drives every output low. After release the counters start at slot 0 of the last line of a frame, so the first `lcd_line` rise comes at N-27 Ts and the first `lcd_frame` rise at N-9 Ts.
- R9: `pix_req` is high for one memory-clock cycle ahead of each display slot. `pix_data` is taken at the clock edge that ends that cycle, which gives D requests per line. Both nibble buses read zero in non-display slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous reset, active high |
| div_sel | input | DW | Pixel-slot divider select (Ts = div_sel+1 clocks) |
| hdisp | input | HW | Display width in groups of 8 Ts, minus one |
| hndisp | input | NW | Non-display width in groups of 8 Ts, minus one (3 or more) |
| nlines | input | VW | Lines per frame minus one |
| pix_data | input | PW | Pixel byte offered to the generator |
| pix_req | output | 1 | Byte taken at the next clock edge |
| lcd_frame | output | 1 | Frame marker |
| lcd_line | output | 1 | Line pulse |
| lcd_shift | output | 1 | Shift clock, odd bytes captured on its falling edge |
| lcd_shift2 | output | 1 | Shift clock, even bytes captured on its rising edge |
| lcd_ud | output | PW/2 | Upper nibble of the current byte |
| lcd_ld | output | PW/2 | Lower nibble of the current byte |

## Verification
The bench keeps the default horizontal field widths (7 and 5 bits) and the 2-bit divider, and narrows the line-count field to 3 bits. This keeps frames short enough that all four divider values can be crossed with four width pairs. These pairs include the smallest legal non-display width, where the line pulse starts 5 Ts into the line. Every edge offset is measured in memory clocks and compared with the Ts formula. Every captured byte is compared with the request count. Every configuration begins with a reset taken while the frame marker is high.

// File: rtl/lcd_tim_pkg.sv
package lcd_tim_pkg;
    localparam int GROUP_TS    = 8;   // slots per width-field unit
    localparam int LINE_PW_TS  = 9;   // line pulse width
    localparam int RISE_BEFORE = 27;  // line rise, counted back from end of non-display
    localparam int FALL_BEFORE = 18;  // line fall, counted back from end of non-display
    localparam int FRAME_LAG   = 9;   // frame edge, counted back from end of non-display

    function automatic int span_ts(input int field);
        return (field + 1) * GROUP_TS;
    endfunction
endpackage

// File: rtl/lcd_pclk_div.sv
module lcd_pclk_div #(
    parameter int DW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] div_sel,
    output logic          tick
);
    typedef struct packed {
        logic [DW-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = (st_q.cnt == div_sel);
        if (tick) st_d.cnt = '0;
        else      st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R1: the phase counter never passes the selected divide value
    assert_div_range_R1: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= div_sel);
    // R1: each slot boundary restarts the phase count
    assert_div_restart_R1: assert property (@(posedge clk) disable iff (rst)
        tick |=> (st_q.cnt == '0));
endmodule

// File: rtl/lcd_hseq.sv
module lcd_hseq #(
    parameter int HW = 7,
    parameter int NW = 5,
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [HW-1:0] hdisp,
    input  logic [NW-1:0] hndisp,
    output logic [CW-1:0] h_nxt,
    output logic          line_end,
    output logic          line_o,
    output logic          shift_o,
    output logic          shift2_o,
    output logic          req_o
);
    import lcd_tim_pkg::*;

    typedef struct packed {
        logic [CW-1:0] h;
        logic          line;
        logic          shift;
        logic          shift2;
    } h_st_t;

    h_st_t         st_d, st_q;
    logic [CW-1:0] nd_len;
    logic [CW-1:0] ln_len;
    logic [CW-1:0] last_h;
    logic          nxt_disp;

    always_comb begin
        nd_len   = CW'(span_ts(int'(hndisp)));
        ln_len   = nd_len + CW'(span_ts(int'(hdisp)));
        last_h   = ln_len - CW'(1);
        line_end = tick && (st_q.h == last_h);
        h_nxt    = (st_q.h == last_h) ? '0 : st_q.h + 1'b1;
        nxt_disp = (h_nxt >= nd_len);
        req_o    = tick && nxt_disp;

        st_d = st_q;
        if (tick) begin
            st_d.h      = h_nxt;
            st_d.line   = (h_nxt >= nd_len - CW'(RISE_BEFORE)) &&
                          (h_nxt <  nd_len - CW'(FALL_BEFORE));
            // nd_len is a multiple of 8, so slot parity equals h parity
            st_d.shift  = nxt_disp && h_nxt[0];
            st_d.shift2 = nxt_disp && h_nxt[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign line_o   = st_q.line;
    assign shift_o  = st_q.shift;
    assign shift2_o = st_q.shift2;

    // R4: line pulse and shift activity never overlap
    assert_line_clear_of_shift_R4: assert property (@(posedge clk) disable iff (rst)
        !(st_q.line && st_q.shift));
    // R5: a shift high phase lasts a single slot
    assert_shift_single_slot_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && st_q.shift) |=> !st_q.shift);
    // R2: slot position stays inside the line
    assert_h_in_line_R2: assert property (@(posedge clk) disable iff (rst)
        st_q.h <= last_h);
    // R9: a request is followed by a display slot, never by the line pulse
    assert_req_then_display_R9: assert property (@(posedge clk) disable iff (rst)
        req_o |=> !st_q.line);
endmodule

// File: rtl/lcd_vseq.sv
module lcd_vseq #(
    parameter int NW = 5,
    parameter int VW = 10,
    parameter int CW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          line_end,
    input  logic [CW-1:0] h_nxt,
    input  logic [NW-1:0] hndisp,
    input  logic [VW-1:0] nlines,
    output logic          frame_o
);
    import lcd_tim_pkg::*;

    typedef struct packed {
        logic [VW-1:0] v;
        logic          frame;
    } v_st_t;

    v_st_t         st_d, st_q;
    logic [CW-1:0] lag_h;
    logic [VW-1:0] v_nxt;

    always_comb begin
        lag_h = CW'(span_ts(int'(hndisp))) - CW'(FRAME_LAG);
        if (line_end) v_nxt = (st_q.v == nlines) ? '0 : st_q.v + 1'b1;
        else          v_nxt = st_q.v;

        st_d = st_q;
        if (tick) begin
            st_d.v     = v_nxt;
            st_d.frame = ((v_nxt == nlines) && (h_nxt >= lag_h)) ||
                         ((v_nxt == '0)     && (h_nxt <  lag_h));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{v: nlines, frame: 1'b0};
        else     st_q <= st_d;
    end

    assign frame_o = st_q.frame;

    // R7: line index stays within the programmed frame
    assert_v_in_frame_R7: assert property (@(posedge clk) disable iff (rst)
        st_q.v <= nlines);
    // R7: the frame marker only rises in the last line of a frame
    assert_frame_rise_last_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.frame) |-> (st_q.v == nlines));
endmodule

// File: rtl/lcd_panel_timer.sv
module lcd_panel_timer #(
    parameter int HW = 7,
    parameter int NW = 5,
    parameter int VW = 10,
    parameter int DW = 2,
    parameter int PW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [DW-1:0]   div_sel,
    input  logic [HW-1:0]   hdisp,
    input  logic [NW-1:0]   hndisp,
    input  logic [VW-1:0]   nlines,
    input  logic [PW-1:0]   pix_data,
    output logic            pix_req,
    output logic            lcd_frame,
    output logic            lcd_line,
    output logic            lcd_shift,
    output logic            lcd_shift2,
    output logic [PW/2-1:0] lcd_ud,
    output logic [PW/2-1:0] lcd_ld
);
    localparam int CW  = $clog2(((2 ** HW) + (2 ** NW)) * lcd_tim_pkg::GROUP_TS);
    localparam int NBW = PW / 2;

    typedef struct packed {
        logic [PW-1:0] px;
    } dat_st_t;

    logic          tick;
    logic          line_end;
    logic [CW-1:0] h_nxt;
    logic          req;
    dat_st_t       dat_d, dat_q;

    lcd_pclk_div #(.DW(DW)) i_div (
        .clk(clk), .rst(rst), .div_sel(div_sel), .tick(tick)
    );

    lcd_hseq #(.HW(HW), .NW(NW), .CW(CW)) i_hseq (
        .clk(clk), .rst(rst), .tick(tick), .hdisp(hdisp), .hndisp(hndisp),
        .h_nxt(h_nxt), .line_end(line_end), .line_o(lcd_line),
        .shift_o(lcd_shift), .shift2_o(lcd_shift2), .req_o(req)
    );

    lcd_vseq #(.NW(NW), .VW(VW), .CW(CW)) i_vseq (
        .clk(clk), .rst(rst), .tick(tick), .line_end(line_end), .h_nxt(h_nxt),
        .hndisp(hndisp), .nlines(nlines), .frame_o(lcd_frame)
    );

    always_comb begin
        dat_d = dat_q;
        if (tick) dat_d.px = req ? pix_data : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) dat_q <= '0;
        else     dat_q <= dat_d;
    end

    assign pix_req = req;
    assign lcd_ud  = dat_q.px[PW-1:NBW];
    assign lcd_ld  = dat_q.px[NBW-1:0];

    // R9: pixel data never shows while the line pulse is active
    assert_data_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        ((lcd_ud != '0) || (lcd_ld != '0)) |-> !lcd_line);
    // R8: while reset is held the request stays low
    assert_reset_quiet_R8: assert property (@(posedge clk)
        rst |-> !pix_req);
endmodule

// File: tb/test_lcd_panel_timer.sv
`timescale 1ns/1ps
module test_lcd_panel_timer;
    localparam int VW = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] div_sel = '0;
    logic [6:0] hdisp = '0;
    logic [4:0] hndisp = 5'd3;
    logic [VW-1:0] nlines = '0;
    logic [7:0] pix_data = '0;
    logic       pix_req, lcd_frame, lcd_line, lcd_shift, lcd_shift2;
    logic [3:0] lcd_ud, lcd_ld;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    lcd_panel_timer #(.HW(7), .NW(5), .VW(VW), .DW(2), .PW(8)) i_lcd_panel_timer (
        .clk(clk), .rst(rst), .div_sel(div_sel), .hdisp(hdisp), .hndisp(hndisp),
        .nlines(nlines), .pix_data(pix_data), .pix_req(pix_req),
        .lcd_frame(lcd_frame), .lcd_line(lcd_line), .lcd_shift(lcd_shift),
        .lcd_shift2(lcd_shift2), .lcd_ud(lcd_ud), .lcd_ld(lcd_ld)
    );

    task automatic chk_eq(input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic run_cfg(input int dv, input int hd, input int hn, input int nl);
        int s, n, d, l, t, limit;
        int lr_t, lf_t, sr_t, sf_t, fr_t;
        int nlr, nfr, lf_since, caps_line, reqs_line, cap_idx, sf_line, seq;
        bit fr_pend, pend, have_sf;
        logic p_line, p_frame, p_sh, p_sh2;
        logic [7:0] p_byte, byte_now;
        logic [13:0] p_all, all_now;

        s = dv + 1; n = (hn + 1) * 8; d = (hd + 1) * 8; l = n + d;
        limit = l * s * (nl + 1) * 4 + 100;
        div_sel = 2'(dv); hdisp = 7'(hd); hndisp = 5'(hn); nlines = VW'(nl);
        rst = 1'b1; pix_data = '0;
        repeat (3) @(negedge clk);
        chk_eq("R8 outputs low in reset",
               int'({lcd_frame, lcd_line, lcd_shift, lcd_shift2, lcd_ud, lcd_ld, pix_req}), 0);

        t = 0; lr_t = 0; lf_t = 0; sr_t = 0; sf_t = 0; fr_t = 0;
        nlr = 0; nfr = 0; lf_since = 0; caps_line = 0; reqs_line = 0;
        cap_idx = 0; sf_line = 0; seq = 0;
        fr_pend = 0; pend = 0; have_sf = 0;
        p_line = 0; p_frame = 0; p_sh = 0; p_sh2 = 0; p_byte = '0; p_all = '0;
        rst = 1'b0;

        while (nfr < 3 && t < limit) begin
            @(negedge clk);
            t++;
            if (pend) begin
                seq++;
                pix_data = 8'(seq);
            end
            pend = pix_req;
            if (pix_req) reqs_line++;
            byte_now = {lcd_ud, lcd_ld};
            all_now  = {lcd_frame, lcd_line, lcd_shift, lcd_shift2, lcd_ud, lcd_ld};

            if (all_now != p_all) chk_eq("R1 pin change on slot boundary", t % s, 0);

            if (!p_sh2 && lcd_shift2) begin
                chk_eq("R6 even byte at shift2 rise", int'(p_byte), cap_idx % 256);
                cap_idx++; caps_line++;
            end
            if (!p_sh && lcd_shift) sr_t = t;
            if (p_sh && !lcd_shift) begin
                chk_eq("R6 odd byte at shift fall", int'(p_byte), cap_idx % 256);
                cap_idx++; caps_line++;
                chk_eq("R5 shift high width", t - sr_t, s);
                chk_eq("R5 shift2 falls with shift", int'({p_sh2, lcd_shift2}), 2);
                if (sf_line > 0) chk_eq("R5 shift period", t - sf_t, 2 * s);
                sf_line++; sf_t = t; have_sf = 1;
            end

            if (!p_line && lcd_line) begin
                if (nlr == 0) chk_eq("R8 first line rise", t, (n - 27) * s);
                else begin
                    chk_eq("R2 line period", t - lr_t, l * s);
                    chk_eq("R6 captures per line", caps_line, d);
                    chk_eq("R9 requests per line", reqs_line, d);
                end
                if (have_sf) chk_eq("R4 shift fall to line rise", t - sf_t, (n - 27) * s);
                chk_eq("R9 nibbles idle in non-display", int'(byte_now), 0);
                lr_t = t; nlr++; caps_line = 0; reqs_line = 0; sf_line = 0;
            end
            if (p_line && !lcd_line) begin
                chk_eq("R3 line pulse width", t - lr_t, 9 * s);
                if (have_sf) chk_eq("R4 shift fall to line fall", t - sf_t, (n - 18) * s);
                if (fr_pend) begin
                    chk_eq("R7 frame setup to line fall", t - fr_t, (l - 9) * s);
                    fr_pend = 0;
                end
                lf_t = t; lf_since++;
            end

            if (!p_frame && lcd_frame) begin
                if (nfr == 0) chk_eq("R8 first frame rise", t, (n - 9) * s);
                else          chk_eq("R7 lines per frame", lf_since, nl + 1);
                nfr++; fr_t = t; fr_pend = 1; lf_since = 0;
            end
            if (p_frame && !lcd_frame) begin
                chk_eq("R7 frame width", t - fr_t, l * s);
                chk_eq("R7 frame hold after line fall", t - lf_t, 9 * s);
            end

            p_line = lcd_line; p_frame = lcd_frame; p_sh = lcd_shift; p_sh2 = lcd_shift2;
            p_byte = byte_now; p_all = all_now;
        end
        if (t >= limit) chk_eq("R2 frame sequence stalled", t, 0);
    endtask

    initial begin
        int hds[4];
        int hns[4];
        hds = '{0, 2, 5, 1};
        hns = '{3, 4, 6, 9};
        for (int dv = 0; dv < 4; dv++) begin
            for (int i = 0; i < 4; i++) begin
                run_cfg(dv, hds[i], hns[i], 1 + ((dv + i) % 3));
            end
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(4 * 190000);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule